// File: doc/BRIEF.md
# Coprocessor Register Window

This block is the bus-facing register window of a vector coprocessor. A host reaches it through one word-addressed 32-bit slave port. The decoder splits that space into three regions. The first is a small bank of control and status words. The second is a window onto the 128-entry general register file. The third is a 512-word window onto a 2048-word microcode store, and a page register picks which quarter of the store that window reaches.

Writing the start bit of the control word launches a run. The block then raises a one-cycle start pulse and reports itself busy until the execution engine signals completion. The execution engine and the DMA engine are separate blocks. They read the microcode store and read and write the general registers through dedicated side ports, which are combinational on the read side.

Bus reads are registered, so read data appears one clock after the request. Accesses that cannot be honoured are refused without side effects and latch a sticky error flag. These are accesses to an unmapped offset, accesses that are not a full aligned word, and partial byte-enable patterns.

Top module: `cw_window`

## Requirements
- R1: After reset, every control/status word, every general register and every microcode word reads as zero, and `start_o`, `busy_o` and `err_o` are low.
- R2: Word offsets 1–3 and 5–11 are plain 32-bit read/write storage that returns exactly the last value written.
- R3: A write to offset 0 with bit 0 set while idle raises `start_o` for exactly one cycle, in the cycle after the write. `busy_o` and read bit 0 of offset 0 then stay 1. A write with bit 0 clear starts nothing.
- R4: A start write while busy is ignored and produces no start pulse.
- R5: Offset 4 is the code page and keeps only its two low bits, so writing 0xFFFFFFFF reads back 3.
- R6: Offset 0x100+n reaches general register n for n in 0..127. The engine read port returns register `ex_gpr_raddr_i` combinationally.
- R7: Offset 0x200+k reaches microcode word page*512+k. The engine read port returns word `ex_code_addr_i` combinationally.
- R8: The engine write port updates a general register. When the bus and the engine write the same register in one cycle, the bus value is kept.
- R9: Offsets 12–0xFF and 0x180–0x1FF are unmapped. Such a read returns 0, such a write changes nothing, and either one sets `err_o`. `err_o` stays set until reset and also reads as bit 1 of offset 0.
- R10: An access whose byte enables are not 4'b1111, or whose byte address has nonzero bits [1:0], is refused. A refused write changes nothing, a refused read returns 0, and either one sets `err_o`.
- R11: A `done_i` pulse ends the run: `busy_o` and read bit 0 of offset 0 return to 0, and a later start write is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables, must be all ones |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| start_o | output | 1 | One-cycle run start pulse |
| busy_o | output | 1 | Run in progress |
| err_o | output | 1 | Sticky refused-access flag |
| done_i | input | 1 | Run completion pulse from the engine |
| ex_gpr_raddr_i | input | 7 | Engine general register read index |
| ex_gpr_rdata_o | output | 32 | Engine general register read data |
| ex_gpr_we_i | input | 1 | Engine general register write enable |
| ex_gpr_waddr_i | input | 7 | Engine general register write index |
| ex_gpr_wdata_i | input | 32 | Engine general register write data |
| ex_code_addr_i | input | 11 | Engine microcode read index |
| ex_code_rdata_o | output | 32 | Engine microcode read data |

## Verification
The bench builds the block with its default parameters: 128 general registers, a 2048-word microcode store and 512-word pages, which gives a 2-bit page field. With those values both ends of the register window and page 0, page 1 and page 3 of the code store are reachable. The bench checks that the last word of the store, index 2047, shows through the top of the window only when page 3 is selected. The 12-entry control bank leaves unmapped holes below 0x100 and between the two windows, and the bench uses these to exercise the error path.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {RGN_CSR, RGN_GPR, RGN_CODE, RGN_NONE} rgn_e;

  localparam int CTRL_IDX = 0;
  localparam int PAGE_IDX = 4;
  localparam int GPR_BASE = 'h100;
  localparam int CODE_BASE = 'h200;
endpackage

// File: rtl/cw_decode.sv
module cw_decode
  import cw_pkg::*;
#(
  parameter int OFF_W      = 10,
  parameter int CSR_N      = 12,
  parameter int GPR_N      = 128,
  parameter int PAGE_WORDS = 512,
  localparam int CSR_IW    = $clog2(CSR_N),
  localparam int GPR_AW    = $clog2(GPR_N),
  localparam int PAGE_AW   = $clog2(PAGE_WORDS)
) (
  input  logic [OFF_W-1:0]   off_i,
  output rgn_e               rgn_o,
  output logic [CSR_IW-1:0]  csr_idx_o,
  output logic [GPR_AW-1:0]  gpr_idx_o,
  output logic [PAGE_AW-1:0] code_off_o
);
  localparam logic [OFF_W-1:0] CSR_END = OFF_W'(CSR_N);
  localparam logic [OFF_W-1:0] GPR_LO  = OFF_W'(GPR_BASE);
  localparam logic [OFF_W-1:0] GPR_HI  = OFF_W'(GPR_BASE + GPR_N);
  localparam logic [OFF_W-1:0] CODE_LO = OFF_W'(CODE_BASE);
  localparam logic [OFF_W:0]   CODE_HI = (OFF_W+1)'(CODE_BASE + PAGE_WORDS);

  logic [OFF_W-1:0] gpr_rel, code_rel;
  assign gpr_rel  = off_i - GPR_LO;
  assign code_rel = off_i - CODE_LO;

  always_comb begin
    if (off_i < CSR_END)                              rgn_o = RGN_CSR;
    else if (off_i >= GPR_LO && off_i < GPR_HI)       rgn_o = RGN_GPR;
    else if (off_i >= CODE_LO && {1'b0, off_i} < CODE_HI) rgn_o = RGN_CODE;
    else                                              rgn_o = RGN_NONE;
  end

  assign csr_idx_o  = CSR_IW'(off_i);
  assign gpr_idx_o  = GPR_AW'(gpr_rel);
  assign code_off_o = PAGE_AW'(code_rel);
endmodule

// File: rtl/cw_csr.sv
module cw_csr
  import cw_pkg::*;
#(
  parameter int CSR_N   = 12,
  parameter int PAGE_W  = 2,
  localparam int CSR_IW = $clog2(CSR_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CSR_IW-1:0] idx_i,
  input  logic [31:0]       wdata_i,
  input  logic              done_i,
  input  logic              err_set_i,
  output logic [31:0]       rdata_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam logic [CSR_IW-1:0] IDX_CTRL = CSR_IW'(CTRL_IDX);
  localparam logic [CSR_IW-1:0] IDX_PAGE = CSR_IW'(PAGE_IDX);
  localparam logic [CSR_IW-1:0] IDX_LAST = CSR_IW'(CSR_N - 1);

  logic [31:0]       rd_w [CSR_N];
  logic [PAGE_W-1:0] page_q;
  logic              busy_q, start_q, err_q;

  for (genvar i = 0; i < CSR_N; i++) begin : g_reg
    if (i == CTRL_IDX) begin : g_ctrl
      assign rd_w[i] = {30'b0, err_q, busy_q};
    end else if (i == PAGE_IDX) begin : g_page
      assign rd_w[i] = {{(32-PAGE_W){1'b0}}, page_q};
    end else begin : g_plain
      logic [31:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            val_q <= '0;
        else if (we_i && idx_i == CSR_IW'(i))   val_q <= wdata_i;
      end
      assign rd_w[i] = val_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        page_q <= '0;
    else if (we_i && idx_i == IDX_PAGE) page_q <= wdata_i[PAGE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (we_i && idx_i == IDX_CTRL && wdata_i[0] && !busy_q) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_set_i) err_q <= 1'b1;
  end

  assign rdata_o = (idx_i <= IDX_LAST) ? rd_w[idx_i] : '0;
  assign page_o  = page_q;
  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign err_o   = err_q;

  // R3
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  // R4
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> !start_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/cw_gpr.sv
module cw_gpr #(
  parameter int N   = 128,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_idx_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic [AW-1:0] ex_raddr_i,
  output logic [31:0]   ex_rdata_o,
  input  logic          ex_we_i,
  input  logic [AW-1:0] ex_waddr_i,
  input  logic [31:0]   ex_wdata_i
);
  logic [31:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else begin
      if (ex_we_i)  mem_q[ex_waddr_i] <= ex_wdata_i;
      if (bus_we_i) mem_q[bus_idx_i]  <= bus_wdata_i; // bus has the last word
    end
  end

  assign bus_rdata_o = mem_q[bus_idx_i];
  assign ex_rdata_o  = mem_q[ex_raddr_i];

  // R8
  bus_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |=> mem_q[$past(bus_idx_i)] == $past(bus_wdata_i));
endmodule

// File: rtl/cw_code.sv
module cw_code #(
  parameter int WORDS = 2048,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic [AW-1:0] ex_addr_i,
  output logic [31:0]   ex_rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (bus_we_i) begin
      mem_q[bus_addr_i] <= bus_wdata_i;
    end
  end

  assign bus_rdata_o = mem_q[bus_addr_i];
  assign ex_rdata_o  = mem_q[ex_addr_i];

  // R7
  code_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |=> mem_q[$past(bus_addr_i)] == $past(bus_wdata_i));
endmodule

// File: rtl/cw_window.sv
module cw_window
  import cw_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CSR_N      = 12,
  parameter int GPR_N      = 128,
  parameter int CODE_WORDS = 2048,
  parameter int PAGE_WORDS = 512,
  localparam int OFF_W     = ADDR_W - 2,
  localparam int CSR_IW    = $clog2(CSR_N),
  localparam int GPR_AW    = $clog2(GPR_N),
  localparam int CODE_AW   = $clog2(CODE_WORDS),
  localparam int PAGE_AW   = $clog2(PAGE_WORDS),
  localparam int PAGE_W    = CODE_AW - PAGE_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [3:0]         be_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               start_o,
  output logic               busy_o,
  output logic               err_o,
  input  logic               done_i,
  input  logic [GPR_AW-1:0]  ex_gpr_raddr_i,
  output logic [31:0]        ex_gpr_rdata_o,
  input  logic               ex_gpr_we_i,
  input  logic [GPR_AW-1:0]  ex_gpr_waddr_i,
  input  logic [31:0]        ex_gpr_wdata_i,
  input  logic [CODE_AW-1:0] ex_code_addr_i,
  output logic [31:0]        ex_code_rdata_o
);
  rgn_e               rgn;
  logic [CSR_IW-1:0]  csr_idx;
  logic [GPR_AW-1:0]  gpr_idx;
  logic [PAGE_AW-1:0] code_off;
  logic [PAGE_W-1:0]  page;
  logic               full_word, acc_ok, acc_bad, wr_ok;
  logic [31:0]        csr_rd, gpr_rd, code_rd, rd_mux, rdata_q;

  cw_decode #(
    .OFF_W(OFF_W), .CSR_N(CSR_N), .GPR_N(GPR_N), .PAGE_WORDS(PAGE_WORDS)
  ) u_dec (
    .off_i(addr_i[ADDR_W-1:2]), .rgn_o(rgn), .csr_idx_o(csr_idx),
    .gpr_idx_o(gpr_idx), .code_off_o(code_off)
  );

  assign full_word = (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
  assign acc_ok    = req_i && full_word && (rgn != RGN_NONE);
  assign acc_bad   = req_i && !acc_ok;
  assign wr_ok     = acc_ok && we_i;

  cw_csr #(.CSR_N(CSR_N), .PAGE_W(PAGE_W)) u_csr (
    .clk_i, .rst_ni,
    .we_i(wr_ok && rgn == RGN_CSR), .idx_i(csr_idx), .wdata_i,
    .done_i, .err_set_i(acc_bad), .rdata_o(csr_rd), .page_o(page),
    .start_o, .busy_o, .err_o
  );

  cw_gpr #(.N(GPR_N)) u_gpr (
    .clk_i, .rst_ni,
    .bus_we_i(wr_ok && rgn == RGN_GPR), .bus_idx_i(gpr_idx),
    .bus_wdata_i(wdata_i), .bus_rdata_o(gpr_rd),
    .ex_raddr_i(ex_gpr_raddr_i), .ex_rdata_o(ex_gpr_rdata_o),
    .ex_we_i(ex_gpr_we_i), .ex_waddr_i(ex_gpr_waddr_i), .ex_wdata_i(ex_gpr_wdata_i)
  );

  cw_code #(.WORDS(CODE_WORDS)) u_code (
    .clk_i, .rst_ni,
    .bus_we_i(wr_ok && rgn == RGN_CODE), .bus_addr_i({page, code_off}),
    .bus_wdata_i(wdata_i), .bus_rdata_o(code_rd),
    .ex_addr_i(ex_code_addr_i), .ex_rdata_o(ex_code_rdata_o)
  );

  always_comb begin
    unique case (rgn)
      RGN_CSR:  rd_mux = csr_rd;
      RGN_GPR:  rd_mux = gpr_rd;
      RGN_CODE: rd_mux = code_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= acc_ok ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;

  // R9
  refused_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (rgn == RGN_NONE)) |=> rdata_o == '0);
  // R10
  refused_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (be_i != 4'hF || addr_i[1:0] != 2'b00)) |=> err_o);
endmodule

// File: tb/cw_window_test.sv
module cw_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, done = 1'b0;
  logic [3:0]  be = 4'hF;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, gpr_rd, code_rd;
  logic        start, busy, err;
  logic [6:0]  gpr_raddr = '0, gpr_waddr = '0;
  logic        gpr_we = 1'b0;
  logic [31:0] gpr_wdata = '0;
  logic [10:0] code_addr = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cw_window uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .start_o(start),
    .busy_o(busy), .err_o(err), .done_i(done),
    .ex_gpr_raddr_i(gpr_raddr), .ex_gpr_rdata_o(gpr_rd),
    .ex_gpr_we_i(gpr_we), .ex_gpr_waddr_i(gpr_waddr), .ex_gpr_wdata_i(gpr_wdata),
    .ex_code_addr_i(code_addr), .ex_code_rdata_o(code_rd)
  );

  localparam int NV = 12;
  localparam logic [9:0]  V_OFF [NV] = '{10'h001, 10'h003, 10'h00B, 10'h009,
    10'h004, 10'h100, 10'h17F, 10'h3FF, 10'h150, 10'h004, 10'h200, 10'h020};
  localparam logic [31:0] V_WD  [NV] = '{32'hDEADBEEF, 32'h0000007F, 32'hA5A55A5A,
    32'h12345678, 32'hFFFFFFFF, 32'h11111111, 32'h7F7F0000, 32'hCAFEF00D,
    32'h3F800000, 32'h00000001, 32'h0BADC0DE, 32'h00000055};
  localparam logic [31:0] V_EXP [NV] = '{32'hDEADBEEF, 32'h0000007F, 32'hA5A55A5A,
    32'h12345678, 32'h00000003, 32'h11111111, 32'h7F7F0000, 32'hCAFEF00D,
    32'h3F800000, 32'h00000001, 32'h0BADC0DE, 32'h00000000};
  // rows 0-3: R2, row 4 and 9: R5, rows 5,6,8: R6, rows 7,10: R7, row 11: R9
  localparam string V_TAG [NV] = '{"R2", "R2", "R2", "R2", "R5", "R6", "R6",
    "R7", "R6", "R5", "R7", "R9"};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [9:0] off, input logic [31:0] d,
                           input logic [3:0] b = 4'hF, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {off, lo}; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic bus_read(input logic [9:0] off, output logic [31:0] d,
                          input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = {off, 2'b00}; be = b;
    @(negedge clk);
    req = 1'b0; be = 4'hF;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1: reset state
    check("R1", {29'b0, start, busy, err}, 32'h0);
    bus_read(10'h000, d); check("R1", d, 32'h0);
    bus_read(10'h001, d); check("R1", d, 32'h0);
    bus_read(10'h17F, d); check("R1", d, 32'h0);
    bus_read(10'h3FF, d); check("R1", d, 32'h0);
    code_addr = 11'd2047; #1; check("R1", code_rd, 32'h0);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      bus_write(V_OFF[i], V_WD[i]);
      bus_read(V_OFF[i], d);
      check(V_TAG[i], d, V_EXP[i]);
    end

    // R9: sticky error visible on port and in control bit 1
    check("R9", {31'b0, err}, 32'h1);
    bus_read(10'h000, d); check("R9", d & 32'h2, 32'h2);
    bus_write(10'h180, 32'hFFFF0000);
    bus_read(10'h180, d); check("R9", d, 32'h0);
    bus_read(10'h100, d); check("R9", d, 32'h11111111);
    bus_read(10'h17F, d); check("R9", d, 32'h7F7F0000);

    // R7: paging and engine read port
    bus_read(10'h3FF, d); check("R7", d, 32'h0);        // page 1 word 1023
    bus_write(10'h004, 32'h3);
    bus_read(10'h3FF, d); check("R7", d, 32'hCAFEF00D); // page 3 word 2047
    bus_write(10'h004, 32'h0);
    bus_read(10'h3FF, d); check("R7", d, 32'h0);        // page 0 word 511
    code_addr = 11'd2047; #1; check("R7", code_rd, 32'hCAFEF00D);
    code_addr = 11'd512;  #1; check("R7", code_rd, 32'h0BADC0DE);

    // R6: engine read port
    gpr_raddr = 7'd127; #1; check("R6", gpr_rd, 32'h7F7F0000);
    gpr_raddr = 7'd80;  #1; check("R6", gpr_rd, 32'h3F800000);

    // R8: engine write, then a same-cycle collision
    @(negedge clk);
    gpr_we = 1'b1; gpr_waddr = 7'd5; gpr_wdata = 32'h00000077;
    @(negedge clk);
    gpr_we = 1'b0;
    bus_read(10'h105, d); check("R8", d, 32'h00000077);
    @(negedge clk);
    gpr_we = 1'b1; gpr_wdata = 32'h00000066;
    req = 1'b1; we = 1'b1; addr = {10'h105, 2'b00}; wdata = 32'h00000099;
    @(negedge clk);
    gpr_we = 1'b0; req = 1'b0; we = 1'b0;
    bus_read(10'h105, d); check("R8", d, 32'h00000099);

    // R3: start pulse timing and busy
    bus_write(10'h000, 32'h0);
    check("R3", {31'b0, start}, 32'h0);
    bus_write(10'h000, 32'h1);
    check("R3", {30'b0, start, busy}, 32'h3);
    @(negedge clk);
    check("R3", {30'b0, start, busy}, 32'h1);
    bus_read(10'h000, d); check("R3", d & 32'h1, 32'h1);

    // R4: start while busy ignored
    bus_write(10'h000, 32'h1);
    check("R4", {31'b0, start}, 32'h0);

    // R11: done ends run, restart allowed
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check("R11", {31'b0, busy}, 32'h0);
    bus_read(10'h000, d); check("R11", d & 32'h1, 32'h0);
    bus_write(10'h000, 32'h1);
    check("R11", {30'b0, start, busy}, 32'h3);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;

    // R10: partial byte enables
    do_reset();
    check("R10", {31'b0, err}, 32'h0);
    bus_write(10'h001, 32'h00000001, 4'b0011);
    check("R10", {31'b0, err}, 32'h1);
    bus_read(10'h001, d); check("R10", d, 32'h0);
    // R10: misaligned byte address
    do_reset();
    bus_write(10'h001, 32'h00000005, 4'hF, 2'b01);
    check("R10", {31'b0, err}, 32'h1);
    bus_read(10'h001, d); check("R10", d, 32'h0);
    bus_write(10'h001, 32'h00000042);
    bus_read(10'h001, d, 4'b0001); check("R10", d, 32'h0);
    bus_read(10'h001, d); check("R2", d, 32'h00000042);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule